// File: doc/BRIEF.md
# Consecutive-Ones Run Detector

This block watches a single serial bit that is sampled on every rising clock edge. Its output goes high in any cycle where the current bit is 1 and the bit was also 1 in each of the previous RUN_LEN-1 cycles. Once a run is long enough, the output stays high for every further 1 in that run. A single 0 ends the run.

The detector does not keep a history of past bits. It holds a small run counter that saturates at RUN_LEN-1, so its state takes ceil(log2(RUN_LEN)) flip-flops. For a run length of 25 that is 5 bits, where a history register would need 24. The output is Mealy: it is decoded from the counter and the present input bit, so it responds to the input within the same cycle.

The input is a plain level, taken every cycle. There is no valid/ready handshake, so the block applies no back-pressure and the source cannot stall it. RUN_LEN defaults to 3, must be at least 2, and is also intended to be used with 25.

Top module: `ones_run_detector`

## Requirements
- R1: The reset input is synchronous and active high. After reset is released, run_hit stays 0 until RUN_LEN consecutive 1s have been presented, counting from the first cycle after reset.
- R2: run_hit is 1 in a cycle exactly when bit_in is 1 in that cycle and bit_in was 1 in each of the preceding RUN_LEN-1 cycles since reset.
- R3: A 0 on bit_in forces run_hit to 0 in that cycle and restarts the run count, so the next RUN_LEN-1 ones produce no hit.
- R4: Within a run longer than RUN_LEN, run_hit stays 1 for every further 1. The run count saturates and never wraps.
- R5: run_hit follows bit_in within the same clock cycle, with no register between them, once the run count is saturated.
- R6: Reset acts only at a clock edge. During the cycle reset is high, run_hit still reflects the state held before that edge. After the edge, the run starts again from zero.
- R7: A run of exactly RUN_LEN-1 ones followed by a 0 produces no hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial input bit, sampled every cycle |
| run_hit | output | 1 | High when the current bit completes or extends a run of RUN_LEN ones |

## Verification
Two instances run side by side on the same stimulus, one with a run length of 3 and one with 25. Their outputs are compared against a bench model that keeps a raw history window of past bits rather than a counter.

Random bits biased toward 1 produce many short runs and check the count restart. Directed runs of exactly RUN_LEN-1 ones separate a correct threshold from an off-by-one. Long runs of 30 ones show saturation as opposed to wrap-around.

A reset pulse in the middle of a run separates a synchronous clear from an asynchronous one. Toggling the input between clock edges shows that the output is Mealy rather than registered.

// File: rtl/ones_run_pkg.sv
package ones_run_pkg;
  // Width of the run counter that must hold values 0..run_len-1.
  function automatic int run_cnt_width(input int run_len);
    int w;
    w = $clog2(run_len);
    if (w < 1) w = 1;
    return w;
  endfunction
endpackage

// File: rtl/ones_run_counter.sv
module ones_run_counter #(
  parameter int LIMIT = 2,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_in,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CAP = W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst)              count <= '0;
    else if (!bit_in)     count <= '0;
    else if (count != CAP) count <= count + 1'b1;
  end
endmodule

// File: rtl/ones_run_decode.sv
module ones_run_decode #(
  parameter int LIMIT = 2,
  parameter int W     = 2
) (
  input  logic         bit_in,
  input  logic [W-1:0] count,
  output logic         hit
);
  localparam logic [W-1:0] CAP = W'(LIMIT);

  always_comb hit = bit_in && (count == CAP);
endmodule

// File: rtl/ones_run_detector.sv
module ones_run_detector #(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic run_hit
);
  localparam int LIMIT = RUN_LEN - 1;
  localparam int CW    = ones_run_pkg::run_cnt_width(RUN_LEN);

  logic [CW-1:0] run_count;

  ones_run_counter #(.LIMIT(LIMIT), .W(CW)) counter_i (
    .clk(clk), .rst(rst), .bit_in(bit_in), .count(run_count)
  );

  ones_run_decode #(.LIMIT(LIMIT), .W(CW)) decode_i (
    .bit_in(bit_in), .count(run_count), .hit(run_hit)
  );
endmodule

// File: rtl/ones_run_detector_chk.sv
module ones_run_detector_chk #(
  parameter int RUN_LEN = 3,
  parameter int CW      = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_in,
  input logic          run_hit,
  input logic [CW-1:0] count
);
  localparam logic [CW-1:0] CAP = CW'(RUN_LEN - 1);

  // R1: the cycle after reset starts from an empty run
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count == '0));

  // R3: a zero clears the run at the next edge
  a_r3_zero_restarts: assert property (@(posedge clk) disable iff (rst)
    !bit_in |=> (count == '0));

  // R3: no hit while the input is zero
  a_r3_no_hit_on_zero: assert property (@(posedge clk) disable iff (rst)
    !bit_in |-> !run_hit);

  // R2: a one below the cap advances the run by exactly one
  a_r2_run_advances: assert property (@(posedge clk) disable iff (rst)
    (bit_in && count != CAP) |=> (count == $past(count) + 1'b1));

  // R4: the run saturates and does not wrap
  a_r4_saturates: assert property (@(posedge clk) disable iff (rst)
    (bit_in && count == CAP) |=> (count == CAP));

  // R2: a hit needs a one in the previous cycle too
  a_r2_hit_needs_prior_one: assert property (@(posedge clk) disable iff (rst)
    run_hit |-> $past(bit_in));
endmodule

bind ones_run_detector ones_run_detector_chk #(
  .RUN_LEN(RUN_LEN), .CW(CW)
) chk_i (
  .clk(clk), .rst(rst), .bit_in(bit_in), .run_hit(run_hit), .count(run_count)
);

// File: tb/ones_run_detector_tb_top.sv
module ones_run_detector_tb_top;
  localparam int SHORT_N = 3;
  localparam int LONG_N  = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic hit_s, hit_l;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] hist = '0;
  int since_rst = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ones_run_detector #(.RUN_LEN(SHORT_N)) dut_i (
    .clk(clk), .rst(rst), .bit_in(bit_in), .run_hit(hit_s)
  );
  ones_run_detector #(.RUN_LEN(LONG_N)) dut_long_i (
    .clk(clk), .rst(rst), .bit_in(bit_in), .run_hit(hit_l)
  );

  // Expected output from a raw history window (hist[0] = previous cycle).
  function automatic logic exp_hit(input int n, input logic xv,
                                   input logic [31:0] h, input int valid);
    if (!xv) return 1'b0;
    if (valid < n - 1) return 1'b0;
    for (int i = 0; i < n - 1; i++) if (!h[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input string which,
                     input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: run_hit=%b expected %b at %0t", tag, which, act, exp, $time);
    end
  endtask

  task automatic update_model(input logic xv, input logic rv);
    if (rv) begin
      hist = '0;
      since_rst = 0;
    end else begin
      hist = {hist[30:0], xv};
      if (since_rst < 1000) since_rst++;
    end
  endtask

  // Drive one cycle, check both instances before the edge, then advance the model.
  task automatic step(input logic xv, input logic rv, input string tag);
    @(negedge clk);
    bit_in = xv;
    rst    = rv;
    #1;
    chk(tag, "N3",  hit_s, exp_hit(SHORT_N, xv, hist, since_rst));
    chk(tag, "N25", hit_l, exp_hit(LONG_N,  xv, hist, since_rst));
    @(posedge clk);
    update_model(xv, rv);
  endtask

  // R5: toggle the input inside one cycle while the short run is saturated.
  task automatic mealy_probe();
    @(negedge clk);
    rst    = 1'b0;
    bit_in = 1'b1;
    #0.5;
    chk("R5", "N3", hit_s, 1'b1);
    bit_in = 1'b0;
    #0.5;
    chk("R5", "N3", hit_s, 1'b0);
    chk("R5", "N25", hit_l, 1'b0);
    @(posedge clk);
    update_model(1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state with the input low
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R1");
    // R1: the first RUN_LEN-1 ones after reset give no hit, the next one does
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R1");
    // R7: exactly RUN_LEN-1 ones then a zero
    step(1'b0, 1'b0, "R3");
    step(1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, "R7");
    step(1'b0, 1'b0, "R7");
    // R4: long run past both thresholds
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, "R4");
    step(1'b0, 1'b0, "R3");
    // R5: same-cycle response
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R2");
    mealy_probe();
    // R6: synchronous reset in the middle of a saturated run
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b1, "R6");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R6");
    // R7 for the long instance: 24 ones then a zero
    step(1'b0, 1'b0, "R3");
    for (int i = 0; i < LONG_N - 1; i++) step(1'b1, 1'b0, "R7");
    step(1'b0, 1'b0, "R7");
    // R2/R3: random bits biased toward ones, with rare resets
    for (int i = 0; i < 3000; i++) begin
      logic xv, rv;
      xv = (($urandom % 16) != 0);
      rv = (($urandom % 500) == 0);
      step(xv, rv, xv ? "R2" : "R3");
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run_hit=x expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule